// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port, fully registered synchronous memory. Address and control are captured on a rising clock edge, and the data beat for that command comes two clock edges later. Write data sits in the same two-edge pipeline as read data, so a read can follow a write, or a write a read, in consecutive cycles with no idle slot on the shared data bus. The bidirectional bus appears here as a data input, a data output and an output-drive enable.

The device is selected by three enables: two active-low and one active-high. A load/advance pin either starts a new command or continues the previous one as a four-beat burst. An active-low clock enable stalls the whole pipeline. Per-lane write selects mask 9-bit byte lanes. An asynchronous output enable can force the output driver off at any moment. The storage is a parameterised array with no reset.

Top module: `zbt_sram`

## Requirements
- R1: A read command accepted at enabled edge k (ld_n=0, rw=1, device selected) places the word at its address on dq_o, with dq_oe high when oe_n is low, during the cycle after enabled edge k+1. A controller therefore samples it at edge k+2.
- R2: A write command accepted at enabled edge k (ld_n=0, rw=0, device selected) stores the dq_i value present at enabled edge k+2.
- R3: bw_n is sampled with each write command or burst step. Bit i low writes lane i, which is bits [9i+8:9i]. Lanes whose bit is high keep their old contents.
- R4: Reads and writes can be issued on consecutive enabled edges in any mix. A read issued one edge after a write to the same address returns the newly written lanes merged with the old ones.
- R5: While cen_n is high, every synchronous input is ignored and all pipeline and output registers hold. The pipeline resumes exactly where it stopped.
- R6: A new command starts only when ce1_n=0, ce2=1, ce3_n=0 and ld_n=0. Any other enable pattern with ld_n=0 is a deselect, which neither reads nor writes. Commands already in the pipeline still complete.
- R7: dq_oe is high only in a cycle that carries a read beat. It is low in the beat slot of a write or a deselect.
- R8: oe_n high forces dq_oe low immediately, without waiting for a clock edge.
- R9: With ld_n=1 the previous command is repeated in the same direction. Its address low two bits step by +1 modulo 4 (linear wrap) and the upper bits stay fixed. An advance after a deselect stays deselected.
- R10: Synchronous active-high rst empties the pipeline and drives dq_oe low. It takes priority over cen_n. Memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| cen_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| ld_n | input | 1 | Low loads a new command, high advances the burst |
| rw | input | 1 | 1 = read, 0 = write |
| oe_n | input | 1 | Asynchronous output enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| addr | input | AW | Word address |
| dq_i | input | LANES*LANE_W | Write data bus |
| dq_o | output | LANES*LANE_W | Read data bus |
| dq_oe | output | 1 | Drive enable for dq_o |

## Verification
Several properties are checked on every cycle: output drive and the asynchronous enable, the freeze of dq_o during a stall, dq_oe following a read command two edges later, and dq_oe staying quiet in the beat slots of writes and deselects. Whether the data is correct can only be shown by the bench scenarios against its reference model. These cover byte merging, forwarding on read-after-write, burst address wrap, and a deselected write that must leave memory untouched.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    localparam int BURST_BITS = 2;

    // Linear burst step within a four-word group
    function automatic logic [BURST_BITS-1:0] burst_next(input logic [BURST_BITS-1:0] a);
        return a + BURST_BITS'(1);
    endfunction

endpackage

// File: rtl/zbt_cmd_stage.sv
module zbt_cmd_stage
    import zbt_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic             sel,
    input  logic             is_wr,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] be_in,
    output logic             vld_q,
    output op_e              op_q,
    output logic [AW-1:0]    addr_q,
    output logic [LANES-1:0] be_q
);

    localparam int HI = AW - BURST_BITS;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
        end else if (en && load) begin
            vld_q <= sel;
        end
    end

    always_ff @(posedge clk) begin
        if (en) begin
            be_q <= be_in;
            if (load) begin
                op_q   <= is_wr ? OP_WR : OP_RD;
                addr_q <= addr;
            end else begin
                addr_q <= {addr_q[AW-1 -: HI], burst_next(addr_q[BURST_BITS-1:0])};
            end
        end
    end

endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    rd_en,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int W     = LANES * LANE_W;
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rd_next;
    logic         same_addr;

    assign same_addr = wr_en && (wr_addr == rd_addr);

    // Per-lane forwarding of a write landing on the same edge as the read
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_next[g*LANE_W +: LANE_W] = (same_addr && wr_be[g])
            ? wr_data[g*LANE_W +: LANE_W]
            : mem[rd_addr][g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_be[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cen_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    ld_n,
    input  logic                    rw,
    input  logic                    oe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] dq_i,
    output logic [LANES*LANE_W-1:0] dq_o,
    output logic                    dq_oe
);

    typedef struct packed {
        logic             vld;
        op_e              op;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] be;
    } beat_t;

    logic             en, sel;
    logic             c1_vld;
    op_e              c1_op;
    logic [AW-1:0]    c1_addr;
    logic [LANES-1:0] c1_be;
    beat_t            s2;
    logic             rd_beat;
    logic             wr_go, rd_go;

    assign en  = !cen_n;
    assign sel = !ce1_n && ce2 && !ce3_n;

    zbt_cmd_stage #(.AW(AW), .LANES(LANES)) u_cmd (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .load   (!ld_n),
        .sel    (sel),
        .is_wr  (!rw),
        .addr   (addr),
        .be_in  (~bw_n),
        .vld_q  (c1_vld),
        .op_q   (c1_op),
        .addr_q (c1_addr),
        .be_q   (c1_be)
    );

    // Second pipeline stage: the command whose data beat is on the bus
    always_ff @(posedge clk) begin
        if (rst) begin
            s2.vld  <= 1'b0;
            rd_beat <= 1'b0;
        end else if (en) begin
            s2      <= '{vld: c1_vld, op: c1_op, addr: c1_addr, be: c1_be};
            rd_beat <= c1_vld && (c1_op == OP_RD);
        end
    end

    assign wr_go = en && s2.vld && (s2.op == OP_WR);
    assign rd_go = en && c1_vld && (c1_op == OP_RD);

    zbt_mem_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_go),
        .wr_addr (s2.addr),
        .wr_be   (s2.be),
        .wr_data (dq_i),
        .rd_en   (rd_go),
        .rd_addr (c1_addr),
        .rd_data (dq_o)
    );

    assign dq_oe = rd_beat && !oe_n;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst,
    input logic         cen_n,
    input logic         ce1_n,
    input logic         ce2,
    input logic         ce3_n,
    input logic         ld_n,
    input logic         rw,
    input logic         oe_n,
    input logic [W-1:0] dq_o,
    input logic         dq_oe
);

    logic sel;
    assign sel = !ce1_n && ce2 && !ce3_n;

    p_oe_async_r8: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe);

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> $stable(dq_o));

    p_read_drive_r1: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !ld_n && sel && rw) ##1 !cen_n ##1 !oe_n |-> dq_oe);

    p_write_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !ld_n && sel && !rw) ##1 !cen_n |=> !dq_oe);

    p_deselect_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !ld_n && !sel) ##1 !cen_n |=> !dq_oe);

    p_reset_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !dq_oe);

endmodule

bind zbt_sram zbt_sram_chk #(.W(LANES*LANE_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cen_n (cen_n),
    .ce1_n (ce1_n),
    .ce2   (ce2),
    .ce3_n (ce3_n),
    .ld_n  (ld_n),
    .rw    (rw),
    .oe_n  (oe_n),
    .dq_o  (dq_o),
    .dq_oe (dq_oe)
);

// File: tb/test_zbt_sram.sv
`timescale 1ns/1ps
module test_zbt_sram;

    localparam int AW = 6, LANES = 4, LW = 9, W = 36, DEPTH = 64;

    logic clk = 1'b0, rst = 1'b1, cen_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic ld_n = 1'b0, rw = 1'b1, oe_n = 1'b0;
    logic [LANES-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [W-1:0] dq_i = '0, dq_o;
    logic dq_oe;

    always #5 clk = ~clk;

    zbt_sram #(.AW(AW), .LANES(LANES), .LANE_W(LW)) i_zbt_sram (
        .clk(clk), .rst(rst), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .ld_n(ld_n), .rw(rw), .oe_n(oe_n), .bw_n(bw_n), .addr(addr), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    typedef struct {
        bit         vld;
        bit         wr;
        int         a;
        bit [3:0]   be;
        logic [W-1:0] d;
    } bcmd_t;

    bcmd_t        hist[$];
    logic [W-1:0] ref_mem [DEPTH];
    bit           exp_rd;
    logic [W-1:0] exp_q;
    int           errors = 0, checks = 0;
    string        cur_req = "R1";
    bit           done = 0;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R7", W'(dq_oe), W'(exp_rd && !oe_n));
        if (exp_rd && !oe_n) chk(cur_req, dq_o, exp_q);
    endtask

    // One clock: drive inputs, advance the reference model, sample at the next falling edge.
    // sc: 0 = all chip enables active, 1 = ce1_n off, 2 = ce2 off, 3 = ce3_n off
    task automatic tick(input bit cen, input bit ld, input int sc, input bit r,
                        input int a, input bit [3:0] bwn, input logic [W-1:0] d);
        bcmd_t c;
        bit wbeat;
        wbeat = (hist.size() >= 2) && hist[$-1].vld && hist[$-1].wr;
        cen_n = cen; ld_n = ld; rw = r; addr = AW'(a); bw_n = bwn;
        ce1_n = (sc == 1); ce2 = (sc != 2); ce3_n = (sc == 3);
        dq_i = wbeat ? hist[$-1].d : 36'h5A5A5A5A5;
        if (!cen) begin
            if (wbeat)
                for (int l = 0; l < LANES; l++)
                    if (hist[$-1].be[l]) ref_mem[hist[$-1].a][l*LW +: LW] = hist[$-1].d[l*LW +: LW];
            exp_rd = (hist.size() >= 1) && hist[$].vld && !hist[$].wr;
            if (exp_rd) exp_q = ref_mem[hist[$].a];
            if (!ld) begin
                c.vld = (sc == 0); c.wr = !r; c.a = a;
            end else begin
                if (hist.size() >= 1) c = hist[$];
                else begin c.vld = 0; c.wr = 0; c.a = 0; end
                c.a = (c.a & ~3) | ((c.a + 1) & 3);
            end
            c.be = ~bwn; c.d = d;
            hist.push_back(c);
            while (hist.size() > 2) void'(hist.pop_front());
        end
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input int a, input logic [W-1:0] d);
        tick(0, 0, 0, 0, a, 4'b0000, d);
    endtask
    task automatic rd(input int a);
        tick(0, 0, 0, 1, a, 4'b1111, '0);
    endtask
    task automatic idle();
        tick(0, 0, 1, 1, 0, 4'b1111, '0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        hist.delete(); exp_rd = 0; exp_q = '0;
        cur_req = "R10";
        chk("R10", W'(dq_oe), '0);
        idle(); idle();

        // Fill memory so every address has a known value
        cur_req = "R2";
        for (int i = 0; i < DEPTH; i++) wr(i, {4'(i), 32'(i * 32'h01010101) ^ 32'hC3A50F96});
        idle(); idle();

        // R1 / R2: write then read after idle slots
        cur_req = "R1";
        wr(5, 36'h123456789); idle(); idle(); rd(5); idle(); idle();
        rd(0); rd(63); idle(); idle();

        // R3: partial byte writes (bw_n low = lane written)
        cur_req = "R3";
        wr(7, 36'hFFFFFFFFF); idle(); idle();
        tick(0, 0, 0, 0, 7, 4'b1010, 36'h000000000); idle(); idle();
        rd(7); idle(); idle();
        tick(0, 0, 0, 0, 8, 4'b0111, 36'hABCDEF012); rd(8); idle(); idle();

        // R4: back-to-back mixes, read right after write to same address
        cur_req = "R4";
        wr(10, 36'h111111111); rd(10); wr(11, 36'h222222222); rd(11);
        rd(10); wr(12, 36'h333333333); tick(0, 0, 0, 0, 12, 4'b1100, 36'h0AAAAAAAA);
        rd(12); rd(11); wr(10, 36'h444444444); rd(10); idle(); idle();

        // R6: deselect variants; writes with an enable off must not land
        cur_req = "R6";
        rd(20); tick(0, 0, 1, 0, 20, 4'b0000, 36'h0BADBAD00);
        tick(0, 0, 2, 0, 20, 4'b0000, 36'h0BADBAD01);
        tick(0, 0, 3, 0, 20, 4'b0000, 36'h0BADBAD02);
        idle(); rd(20); idle(); idle();

        // R9: bursts with linear wrap, and advance after deselect
        cur_req = "R9";
        wr(14, 36'h900000001);
        tick(0, 1, 1, 1, 0, 4'b0000, 36'h900000002);
        tick(0, 1, 1, 1, 0, 4'b0000, 36'h900000003);
        tick(0, 1, 1, 1, 0, 4'b0000, 36'h900000004);
        rd(12);
        tick(0, 1, 0, 1, 0, 4'b1111, '0);
        tick(0, 1, 0, 1, 0, 4'b1111, '0);
        tick(0, 1, 0, 1, 0, 4'b1111, '0);
        idle();
        tick(0, 1, 0, 0, 0, 4'b0000, 36'h0DEADDEAD);
        tick(0, 1, 0, 0, 0, 4'b0000, 36'h0DEADDEAD);
        rd(13); rd(14); idle(); idle();

        // R5: clock-enable stalls in the middle of a mixed stream
        cur_req = "R5";
        wr(30, 36'h555555555); tick(1, 0, 0, 1, 31, 4'b1111, '0);
        rd(30); tick(1, 0, 0, 0, 30, 4'b0000, 36'h0FFFFFFFF);
        tick(1, 1, 2, 0, 30, 4'b0000, '0); wr(31, 36'h666666666);
        tick(1, 0, 0, 1, 0, 4'b1111, '0); rd(31); tick(1, 0, 0, 1, 0, 4'b1111, '0);
        idle(); idle(); rd(30); idle(); idle();

        // R8: asynchronous output enable while a read beat is on the bus
        cur_req = "R8";
        rd(30); idle();
        oe_n = 1'b1; #1;
        chk("R8", W'(dq_oe), '0);
        oe_n = 1'b0; #1;
        chk("R8", W'(dq_oe), W'(1));
        idle(); idle();

        // Mixed random traffic covering all of the above
        cur_req = "R4";
        for (int i = 0; i < 400; i++) begin
            int unsigned rr;
            rr = $urandom;
            tick(rr[0] & rr[1] & rr[2], rr[3] & rr[4], (rr[5] & rr[6]) ? 1 + int'(rr[8:7] % 3) : 0,
                 rr[9], int'(rr[15:10]), rr[19:16], {rr[31:28], $urandom});
            oe_n = (rr[27:24] == 4'hF);
        end
        oe_n = 1'b0;
        idle(); idle(); idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule